// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block sits on the host side of a parallel NOR flash and decides when an embedded program or erase operation has finished. After a start pulse it reads the device status byte again and again over a simple request/acknowledge read port, and compares the toggle bit between the two reads of each pair. If the toggle bit holds still, the operation is complete. While it keeps flipping and the timeout flag stays low, the block starts a new pair of reads.

When the timeout flag is seen high during a toggling pair, the block makes one confirming pair of reads. A quiet confirming pair means success. A confirming pair that still toggles means the device gave up. The block then writes the reset command so that the device returns to array reads, and reports failure. A programmable limit on the number of toggling pairs also forces the failure path, so a stuck device cannot hang the poller. An abort pulse drops all progress. The next start always begins with a fresh pair of reads.

Top module: `flash_toggle_poller`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, fail_o, rd_req_o and wr_req_o are all low.
- R2: A start_i pulse while idle clears done_o and fail_o, raises busy_o and begins the first read on the next cycle. A start_i pulse while busy has no effect on the reads made or on the result.
- R3: rd_req_o stays high until rd_ack_i is seen. Each acknowledge consumes one status byte from rd_data_i. Reads are taken in pairs, and the second read of a pair is requested only after the first read has been acknowledged.
- R4: If bit 6 is equal in both bytes of a pair, done_o rises in the cycle after the second acknowledge and no write is made. Bit 5 and all other bits of such a pair have no effect.
- R5: If bit 6 differs within a pair and bit 5 of the second byte is 0, the block starts a new pair of reads. No byte from an earlier pair is used again.
- R6: If bit 6 differs within a pair and bit 5 of the second byte is 1, one confirming pair is read. If bit 6 is equal across that confirming pair, done_o rises in the cycle after its second acknowledge.
- R7: If bit 6 still differs across the confirming pair, the block raises wr_req_o with wr_data_o = 0xF0 and holds it until wr_ack_i. fail_o rises in the cycle after that acknowledge.
- R8: A toggling pair with bit 5 low whose 1-based count reaches max_iter_i takes the failure path of R7 instead of starting another pair.
- R9: done_o and fail_o hold their value while idle until the next accepted start_i. The two are never high together, and neither is high while busy_o is high.
- R10: abort_i while busy returns the block to idle on the next cycle with no request and no result. The next start then begins a fresh first pair. abort_i while idle has no effect.
- R11: rd_req_o and wr_req_o are never high in the same cycle, and wr_data_o is 0xF0 whenever wr_req_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a poll (single-cycle pulse) |
| abort_i | input | 1 | Abandon the poll in progress |
| max_iter_i | input | IW (8) | Limit on toggling pairs that have bit 5 low |
| rd_req_o | output | 1 | Status read request |
| rd_ack_i | input | 1 | Read acknowledge; rd_data_i is valid with it |
| rd_data_i | input | DW (8) | Status byte returned by the device |
| wr_req_o | output | 1 | Reset command write request |
| wr_ack_i | input | 1 | Write acknowledge |
| wr_data_o | output | DW (8) | Write data, 0xF0 |
| done_o | output | 1 | Operation completed successfully |
| fail_o | output | 1 | Operation failed; reset command issued |
| busy_o | output | 1 | Poll in progress |

## Verification
With a read latency of L idle cycles before each acknowledge, a read takes 2+L cycles. The first request comes up in the cycle after start_i is sampled. For r reads, done_o is therefore due exactly r·(2+L) clock edges after the start edge, and fail_o is due one edge later because the reset write is acknowledged with no wait. The bench models the device at the falling edge. It notes the cycle counter when it drives start_i, and compares the number of rising edges elapsed before the result flag appears against that formula. The read count, the write count and the write data are compared as well.

// File: rtl/ftp_pkg.sv
package ftp_pkg;
  localparam int unsigned TOG_BIT = 6;
  localparam int unsigned TMO_BIT = 5;
  localparam logic [7:0]  RST_CMD = 8'hF0;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_WR
  } state_e;

  typedef enum logic [1:0] {
    EV_DONE,
    EV_RETRY,
    EV_CONFIRM,
    EV_FAIL
  } eval_e;
endpackage

// File: rtl/ftp_pair_eval.sv
module ftp_pair_eval
  import ftp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] first_i,
  input  logic [DW-1:0] second_i,
  input  logic          confirm_i,
  input  logic          limit_hit_i,
  output eval_e         ev_o
);
  logic toggled;
  assign toggled = first_i[TOG_BIT] ^ second_i[TOG_BIT];

  always_comb begin
    if (!toggled)                ev_o = EV_DONE;
    else if (confirm_i)          ev_o = EV_FAIL;
    else if (second_i[TMO_BIT])  ev_o = EV_CONFIRM;
    else if (limit_hit_i)        ev_o = EV_FAIL;
    else                         ev_o = EV_RETRY;
  end
endmodule

// File: rtl/ftp_iter_cnt.sv
module ftp_iter_cnt #(
  parameter int unsigned IW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [IW-1:0] max_i,
  output logic          limit_hit_o
);
  logic [IW-1:0] cnt_q;
  logic [IW:0]   cnt_nxt;

  // count of the pair under evaluation, one-based
  assign cnt_nxt     = {1'b0, cnt_q} + 1'b1;
  assign limit_hit_o = cnt_nxt >= {1'b0, max_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (inc_i && !cnt_nxt[IW]) cnt_q <= cnt_nxt[IW-1:0];
  end
endmodule

// File: rtl/ftp_result_reg.sv
module ftp_result_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_done_i,
  input  logic set_fail_i,
  output logic done_o,
  output logic fail_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
    end else if (clr_i) begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      if (set_done_i) done_o <= 1'b1;
      if (set_fail_i) fail_o <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
  import ftp_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [IW-1:0] max_iter_i,
  output logic          rd_req_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_req_o,
  input  logic          wr_ack_i,
  output logic [DW-1:0] wr_data_o,
  output logic          done_o,
  output logic          fail_o,
  output logic          busy_o
);
  state_e        state_q;
  logic [DW-1:0] first_q;
  logic          confirm_q;
  logic          limit_hit;
  eval_e         ev;
  logic          kill;
  logic          accept;
  logic          pair_end;

  assign busy_o    = state_q != ST_IDLE;
  assign kill      = abort_i && busy_o;
  assign accept    = (state_q == ST_IDLE) && start_i;
  assign pair_end  = (state_q == ST_RD_B) && rd_ack_i && !kill;
  assign rd_req_o  = (state_q == ST_RD_A) || (state_q == ST_RD_B);
  assign wr_req_o  = state_q == ST_WR;
  assign wr_data_o = DW'(RST_CMD);

  ftp_pair_eval #(.DW(DW)) u_eval (
    .first_i     (first_q),
    .second_i    (rd_data_i),
    .confirm_i   (confirm_q),
    .limit_hit_i (limit_hit),
    .ev_o        (ev)
  );

  ftp_iter_cnt #(.IW(IW)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (accept),
    .inc_i       (pair_end && ev == EV_RETRY),
    .max_i       (max_iter_i),
    .limit_hit_o (limit_hit)
  );

  ftp_result_reg u_res (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (accept),
    .set_done_i (pair_end && ev == EV_DONE),
    .set_fail_i ((state_q == ST_WR) && wr_ack_i && !kill),
    .done_o     (done_o),
    .fail_o     (fail_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      first_q   <= '0;
      confirm_q <= 1'b0;
    end else if (kill) begin
      state_q   <= ST_IDLE;
      confirm_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_RD_A;
          confirm_q <= 1'b0;
        end
        ST_RD_A: if (rd_ack_i) begin
          first_q <= rd_data_i;
          state_q <= ST_RD_B;
        end
        ST_RD_B: if (rd_ack_i) begin
          unique case (ev)
            EV_DONE:    state_q <= ST_IDLE;
            EV_RETRY:   state_q <= ST_RD_A;
            EV_CONFIRM: begin
              confirm_q <= 1'b1;
              state_q   <= ST_RD_A;
            end
            EV_FAIL:    state_q <= ST_WR;
            default:    state_q <= ST_IDLE;
          endcase
        end
        ST_WR: if (wr_ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ftp_checker.sv
module ftp_checker #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          abort_i,
  input logic          rd_req_o,
  input logic          rd_ack_i,
  input logic          wr_req_o,
  input logic          wr_ack_i,
  input logic [DW-1:0] wr_data_o,
  input logic          done_o,
  input logic          fail_o,
  input logic          busy_o
);
  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o)); // R11
  AST_WR_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> wr_data_o == DW'(8'hF0)); // R11
  AST_RESULT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o)); // R9
  AST_NO_RESULT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o && !fail_o); // R9
  AST_START_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && rd_req_o); // R2
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o); // R9
  AST_FAIL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !start_i |=> fail_o); // R9
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i && !abort_i |=> rd_req_o); // R3
  AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ack_i && !abort_i |=> wr_req_o); // R7
  AST_FAIL_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> $past(wr_req_o && wr_ack_i)); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i && busy_o |=> !busy_o && !rd_req_o && !wr_req_o && !done_o && !fail_o); // R10
endmodule

bind flash_toggle_poller ftp_checker #(.DW(DW)) u_ftp_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .abort_i   (abort_i),
  .rd_req_o  (rd_req_o),
  .rd_ack_i  (rd_ack_i),
  .wr_req_o  (wr_req_o),
  .wr_ack_i  (wr_ack_i),
  .wr_data_o (wr_data_o),
  .done_o    (done_o),
  .fail_o    (fail_o),
  .busy_o    (busy_o)
);

// File: tb/flash_toggle_poller_tb_top.sv
module flash_toggle_poller_tb_top;
  localparam int DW = 8;
  localparam int IW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          abort_i = 1'b0;
  logic [IW-1:0] max_iter_i = 8'd4;
  logic          rd_req_o;
  logic          rd_ack_i = 1'b0;
  logic [DW-1:0] rd_data_i = '0;
  logic          wr_req_o;
  logic          wr_ack_i = 1'b0;
  logic [DW-1:0] wr_data_o;
  logic          done_o, fail_o, busy_o;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic [7:0] scr [0:31];
  int  lat = 0;
  logic resp_clr = 1'b0;
  int  rd_ptr = 0, rd_wait = 0, wr_cnt = 0;
  logic [7:0] wr_last = '0;

  flash_toggle_poller #(.DW(DW), .IW(IW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .abort_i(abort_i),
    .max_iter_i(max_iter_i), .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .wr_req_o(wr_req_o), .wr_ack_i(wr_ack_i),
    .wr_data_o(wr_data_o), .done_o(done_o), .fail_o(fail_o), .busy_o(busy_o)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // device model: acks after lat idle cycles, writes acked at once
  always @(negedge clk_i) begin
    if (resp_clr) begin
      rd_ack_i = 1'b0; wr_ack_i = 1'b0; rd_ptr = 0; rd_wait = 0; wr_cnt = 0; wr_last = '0;
    end else begin
      if (rd_ack_i) begin
        rd_ack_i = 1'b0; rd_wait = 0;
      end else if (rd_req_o) begin
        if (rd_wait >= lat) begin
          rd_ack_i = 1'b1; rd_data_i = scr[rd_ptr % 32]; rd_ptr++;
        end else rd_wait++;
      end
      if (wr_ack_i) wr_ack_i = 1'b0;
      else if (wr_req_o) begin
        wr_ack_i = 1'b1; wr_last = wr_data_o; wr_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // t toggling pairs with bit 5 low, then terminal kind: 0 quiet, 1 confirm quiet, 2 confirm toggles
  task automatic fill(input int t, input int kind);
    for (int i = 0; i < 32; i += 2) begin
      logic [7:0] j;
      j = 8'((i * 7 + t * 3) & 8'h9F);
      scr[i] = 8'h40 | j; scr[i+1] = 8'h00 | j;
    end
    case (kind)
      0: begin scr[2*t] = 8'h40 | scr[2*t]; scr[2*t+1] = 8'h60 | scr[2*t+1]; end
      1: begin scr[2*t] = 8'h00; scr[2*t+1] = 8'h60; scr[2*t+2] = 8'h20; scr[2*t+3] = 8'h24; end
      default: begin scr[2*t] = 8'h40; scr[2*t+1] = 8'h20; scr[2*t+2] = 8'h60; scr[2*t+3] = 8'h00; end
    endcase
  endtask

  task automatic run(input int l, input int mx, input bit exp_fail, input int reads,
                     input int stray_start, input string req);
    int c0, el;
    @(negedge clk_i); resp_clr = 1'b1; lat = l; max_iter_i = IW'(mx);
    @(negedge clk_i); resp_clr = 1'b0; start_i = 1'b1; c0 = cyc;
    @(negedge clk_i); start_i = 1'b0;
    check(busy_o && !done_o && !fail_o, "R2 start accepted", int'(busy_o), 1);
    for (int k = 0; k < 400 && !(done_o || fail_o); k++) begin
      if (k == stray_start) start_i = 1'b1; else start_i = 1'b0;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    el = cyc - c0;
    check(fail_o == exp_fail && done_o == !exp_fail, {req, " result"}, int'(fail_o), int'(exp_fail));
    check(rd_ptr == reads, {req, " read count"}, rd_ptr, reads);
    check(el == reads * (2 + l) + int'(exp_fail), {req, " latency"}, el, reads * (2 + l) + int'(exp_fail));
    check(wr_cnt == int'(exp_fail), "R7 write count", wr_cnt, int'(exp_fail));
    if (exp_fail) check(wr_last == 8'hF0, "R7 reset command", wr_last, 8'hF0);
    check(!busy_o && !rd_req_o && !wr_req_o, "R11 idle after result", int'(busy_o), 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) scr[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !fail_o && !rd_req_o && !wr_req_o, "R1 reset state", int'(busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !rd_req_o, "R1 idle after reset", int'(rd_req_o), 0);

    // abort while idle has no effect (R10)
    abort_i = 1'b1; @(negedge clk_i); abort_i = 1'b0; @(negedge clk_i);
    check(!busy_o && !done_o && !fail_o, "R10 idle abort", int'(busy_o), 0);

    // sweep: R4 (kind 0), R5 (t>0), R6 (kind 1), R7 (kind 2), R8 (t>=max)
    for (int mx = 1; mx <= 4; mx++)
      for (int t = 0; t <= 3; t++)
        for (int kind = 0; kind <= 2; kind++) begin
          int l, reads; bit ef;
          l = (t + mx + kind) % 3;
          fill(t, kind);
          if (t >= mx) begin ef = 1'b1; reads = 2 * mx; end
          else if (kind == 0) begin ef = 1'b0; reads = 2 * t + 2; end
          else begin ef = (kind == 2); reads = 2 * t + 4; end
          run(l, mx, ef, reads, -1, t >= mx ? "R8" : (kind == 0 ? "R4" : (kind == 1 ? "R6" : "R7")));
          if (t > 0 && t < mx) check(rd_ptr > 2, "R5 repolled", rd_ptr, reads);
        end

    // stray start while busy is ignored (R2)
    fill(1, 1);
    run(1, 4, 1'b0, 6, 3, "R2 stray start");

    // results hold while idle (R9), then cleared by start
    repeat (5) @(negedge clk_i);
    check(done_o && !fail_o, "R9 done held", int'(done_o), 1);
    fill(2, 0);
    lat = 2;
    start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
    check(!done_o && busy_o, "R9 start clears done", int'(done_o), 0);

    // abort mid-pair, then a fresh start must not reuse the old first byte (R10)
    for (int k = 0; k < 50 && rd_ptr < 1; k++) @(negedge clk_i);
    @(negedge clk_i);
    abort_i = 1'b1; @(negedge clk_i); abort_i = 1'b0;
    check(!busy_o && !rd_req_o && !wr_req_o && !done_o && !fail_o, "R10 abort to idle", int'(busy_o), 0);
    for (int i = 0; i < 32; i++) scr[i] = 8'h00;
    run(2, 4, 1'b0, 2, -1, "R10 fresh pair");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule